// File: doc/BRIEF.md
# Debug Port Read-Out Protection Lock

This block guards on-chip program memory against an in-circuit debug port. It keeps one protection bit that behaves like a non-volatile cell: the bit keeps its value through resets. Firmware can set it only during a short boot window that opens after each reset. While the bit is clear, every debug command is allowed. While it is set, the only command allowed is a whole-array erase; every other debug operation is refused with a reject pulse.

Protection is removed by a fixed sequence, and the order matters. First a granted whole-array erase must report completion from the flash. Then a chip reset must follow. A reset by itself does not clear the bit. A reset that arrives while the erase is still running does not clear it either, and that reset also discards the partly completed removal sequence.

The controller is built around four states:
- `ST_OPEN`: unprotected.
- `ST_LOCKED`: protected and idle.
- `ST_ERASING`: a global erase has been granted and the block is waiting for erase-done.
- `ST_CLEARED`: the erase has completed and the block is waiting for a reset.

The transitions are:
- `OPEN->LOCKED`: set accepted inside the window.
- `LOCKED->ERASING`: global erase granted.
- `ERASING->CLEARED`: erase-done received.
- `reset->OPEN`: the stored bit is clear, or the state was `CLEARED`.
- `reset->LOCKED`: any other case.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `grant_o` and `reject_o` are low. `secure_o` always shows the stored protection bit, and that bit powers up clear.
- R2: `window_o` is high from the release of reset for exactly 16 cycles. It then stays low until the next reset.
- R3: A `set_req_i` strobe sets the protection bit, visible on `secure_o` the next cycle, only when `window_o` is high. Outside the window the strobe is ignored.
- R4: While `secure_o` is low, any opcode presented with `cmd_valid_i` gives a one-cycle `grant_o` on the next cycle, and `reject_o` stays low.
- R5: While `secure_o` is high, opcode 3'b111 (whole-array erase) is granted on the next cycle.
- R6: While `secure_o` is high, opcodes 3'b000 to 3'b110 give a one-cycle `reject_o` on the next cycle, and `grant_o` stays low.
- R7: Once the protection bit is set, neither firmware nor a reset alone clears it. This includes a reset that comes after a granted erase but before `erase_done_i`.
- R8: An `erase_done_i` received after a granted erase, followed by a reset, clears the protection bit. Until that reset, the bit stays set and filtering stays active.
- R9: `grant_o` and `reject_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| set_req_i | input | 1 | Firmware request to set protection |
| cmd_valid_i | input | 1 | Debug command strobe |
| cmd_op_i | input | 3 | Debug opcode, 3'b111 = whole-array erase |
| erase_done_i | input | 1 | Flash reports global erase finished |
| grant_o | output | 1 | Command allowed (one-cycle pulse) |
| reject_o | output | 1 | Command refused (one-cycle pulse) |
| secure_o | output | 1 | Protection bit state |
| window_o | output | 1 | Boot window in which set is accepted |

## Verification
The bench sends all eight opcodes twice: once with protection clear and once with it set. This separates a filter that depends on the stored bit from one that depends on the opcode alone.

Set strobes are placed on the last cycle inside the window and again just after the window closes, so the window length is pinned to the exact cycle. The removal sequence is tried in three ways: reset with no erase, reset during an erase, and erase-done followed by reset. Only the last of these may clear the bit.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_GLOBAL_ERASE = 3'b111;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_LOCKED,
        ST_ERASING,
        ST_CLEARED
    } lock_state_t;
endpackage

// File: rtl/dbg_lock_window.sv
module dbg_lock_window #(
    parameter int WIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_o
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign win_o = (cnt_q != LIMIT);
endmodule

// File: rtl/dbg_lock_filter.sv
module dbg_lock_filter
    import dbg_lock_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            secure_i,
    output logic            erase_grant_o,
    output logic            grant_o,
    output logic            reject_o
);
    logic is_erase;
    logic allow;
    logic grant_q;
    logic reject_q;

    always_comb begin
        is_erase      = (op_i == OP_GLOBAL_ERASE);
        allow         = !secure_i || is_erase;
        erase_grant_o = rst_n && valid_i && is_erase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            grant_q  <= valid_i && allow;
            reject_q <= valid_i && !allow;
        end
    end

    assign grant_o  = grant_q;
    assign reject_o = reject_q;
endmodule

// File: rtl/dbg_lock_fsm.sv
module dbg_lock_fsm
    import dbg_lock_pkg::*;
#(
    parameter bit NV_INIT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_ok_i,
    input  logic        erase_grant_i,
    input  logic        erase_done_i,
    output logic        secure_o,
    output lock_state_t state_o
);
    // Stored protection cell: not cleared by reset, it only follows the removal sequence.
    logic        nv_q    = NV_INIT;
    lock_state_t state_q = ST_OPEN;
    lock_state_t state_d;

    // Transitions taken while out of reset.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:    if (set_ok_i)      state_d = ST_LOCKED;
            ST_LOCKED:  if (erase_grant_i) state_d = ST_ERASING;
            ST_ERASING: if (erase_done_i)  state_d = ST_CLEARED;
            ST_CLEARED: state_d = ST_CLEARED;
            default:    state_d = ST_OPEN;
        endcase
    end

    // State register, with the stored cell handled in the same process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (nv_q && state_q != ST_CLEARED) begin
                state_q <= ST_LOCKED;
            end else begin
                state_q <= ST_OPEN;
                nv_q    <= 1'b0;
            end
        end else begin
            state_q <= state_d;
            if (state_q == ST_OPEN && set_ok_i) begin
                nv_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        secure_o = nv_q;
        state_o  = state_q;
    end
endmodule

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
    import dbg_lock_pkg::*;
#(
    parameter int WIN_CYCLES = 16,
    parameter bit NV_INIT    = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_req_i,
    input  logic            cmd_valid_i,
    input  logic [OP_W-1:0] cmd_op_i,
    input  logic            erase_done_i,
    output logic            grant_o,
    output logic            reject_o,
    output logic            secure_o,
    output logic            window_o
);
    logic        win;
    logic        secure;
    logic        erase_grant;
    lock_state_t state;

    dbg_lock_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .win_o (win)
    );

    dbg_lock_fsm #(.NV_INIT(NV_INIT)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_ok_i      (set_req_i && win),
        .erase_grant_i (erase_grant),
        .erase_done_i  (erase_done_i),
        .secure_o      (secure),
        .state_o       (state)
    );

    dbg_lock_filter u_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (cmd_valid_i),
        .op_i          (cmd_op_i),
        .secure_i      (secure),
        .erase_grant_o (erase_grant),
        .grant_o       (grant_o),
        .reject_o      (reject_o)
    );

    assign secure_o = secure;
    assign window_o = win;
endmodule

// File: rtl/dbg_lock_chk.sv
module dbg_lock_chk
    import dbg_lock_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            set_req_i,
    input logic            cmd_valid_i,
    input logic [OP_W-1:0] cmd_op_i,
    input logic            grant_o,
    input logic            reject_o,
    input logic            secure_o,
    input logic            window_o
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    a_r4_open_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !secure_o) |=> (grant_o && !reject_o));

    a_r5_erase_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && secure_o && cmd_op_i == OP_GLOBAL_ERASE) |=> grant_o);

    a_r6_block: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && secure_o && cmd_op_i != OP_GLOBAL_ERASE) |=> (reject_o && !grant_o));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |=> secure_o);

    a_r3_late_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req_i && !window_o && !secure_o) |=> !secure_o);

    a_r2_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
        !window_o |=> !window_o);
endmodule

bind dbg_lock_ctrl dbg_lock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_req_i   (set_req_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .grant_o     (grant_o),
    .reject_o    (reject_o),
    .secure_o    (secure_o),
    .window_o    (window_o)
);

// File: tb/dbg_lock_ctrl_test.sv
module dbg_lock_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_req_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_op_i = 3'b000;
    logic       erase_done_i = 1'b0;
    logic       grant_o, reject_o, secure_o, window_o;

    int vectors = 0;
    int errors  = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic       sent_d = 1'b0;

    always #2 clk = ~clk;

    dbg_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .set_req_i(set_req_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .erase_done_i(erase_done_i),
        .grant_o(grant_o), .reject_o(reject_o), .secure_o(secure_o), .window_o(window_o)
    );

    always @(posedge clk) sent_d <= cmd_valid_i && rst_n;

    // Monitor: one expected {grant,reject} per accepted command; silence otherwise.
    always @(negedge clk) begin
        if (sent_d) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if ({grant_o, reject_o} !== e) begin
                errors++;
                $display("FAIL %s grant/reject actual=%b expected=%b", t, {grant_o, reject_o}, e);
            end
        end else if (grant_o || reject_o) begin
            vectors++;
            errors++;
            $display("FAIL R9 spurious pulse actual=%b expected=00", {grant_o, reject_o});
        end
    end

    task automatic check(input string t, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic g, input logic r, input string t);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        exp_q.push_back({g, r});
        tag_q.push_back(t);
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 no grant in reset", grant_o, 1'b0);
        check("R1 no reject in reset", reject_o, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic pulse_set();
        @(negedge clk);
        set_req_i = 1'b1;
        @(negedge clk);
        set_req_i = 1'b0;
    endtask

    task automatic wait_window_shut();
        while (window_o) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 powers up clear", secure_o, 1'b0);
        rst_n = 1'b1;
        // R2: exact window length
        check("R2 window open at release", window_o, 1'b1);
        repeat (15) @(negedge clk);
        check("R2 window open on cycle 16", window_o, 1'b1);
        @(negedge clk);
        check("R2 window shut after 16", window_o, 1'b0);
        // R3: late set ignored
        pulse_set();
        check("R3 late set ignored", secure_o, 1'b0);
        // R4: open, every opcode granted
        for (int op = 0; op < 8; op++) send(3'(op), 1'b1, 1'b0, "R4 open grant");

        // R3: set on last window cycle accepted
        do_reset();
        repeat (15) @(negedge clk);
        set_req_i = 1'b1;
        @(negedge clk);
        set_req_i = 1'b0;
        check("R3 set in last window cycle", secure_o, 1'b1);
        // R6 / R5
        for (int op = 0; op < 7; op++) send(3'(op), 1'b0, 1'b1, "R6 blocked");
        // R7: reset alone keeps protection
        do_reset();
        check("R7 survives reset", secure_o, 1'b1);
        pulse_set();
        check("R7 set while armed keeps bit", secure_o, 1'b1);
        send(3'b010, 1'b0, 1'b1, "R6 blocked after reset");
        send(3'b111, 1'b1, 1'b0, "R5 erase granted");
        // reset before erase_done
        do_reset();
        check("R7 reset mid-erase keeps bit", secure_o, 1'b1);
        wait_window_shut();
        // erase_done before grant ignored (LOCKED state)
        @(negedge clk); erase_done_i = 1'b1; @(negedge clk); erase_done_i = 1'b0;
        do_reset();
        check("R8 done without erase ignored", secure_o, 1'b1);
        // full sequence
        send(3'b111, 1'b1, 1'b0, "R5 erase granted again");
        @(negedge clk); erase_done_i = 1'b1; @(negedge clk); erase_done_i = 1'b0;
        check("R8 still armed before reset", secure_o, 1'b1);
        send(3'b001, 1'b0, 1'b1, "R8 filter active before reset");
        do_reset();
        check("R8 cleared after erase+reset", secure_o, 1'b0);
        send(3'b001, 1'b1, 1'b0, "R8 open after clear");
        // can rearm in next window
        pulse_set();
        check("R3 rearm in window", secure_o, 1'b1);
        send(3'b100, 1'b0, 1'b1, "R6 blocked after rearm");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule